// File: doc/BRIEF.md
# Boundary Scan Cell Chain with Preload Latch

This block is the data register that sits behind a test access port and gives serial access to the device pins. Each cell of the chain holds one shift flop and one parallel holding latch. While the instruction decoder selects the chain, three strobes act on it. A capture strobe snapshots the pin bus into the shift flops. A shift strobe moves the chain one place toward the serial output and takes a new bit in from the serial input. An update strobe copies the shift flops into the holding latches. The holding latches then drive the pins when an external test instruction is active.

One cell, the output-enable cell (index 47 by default), has a special job. Its latched value is brought out on its own pin as the output-bus enable. A 1 lets the output drivers drive, and a 0 puts the output bus into high impedance. At power-up and during the Test-Logic-Reset state this latch presets to 1. Every other latch presets to 0. To load this cell, software shifts the wanted bit into that position and then passes through Update-DR. Pin values at the capture edge are asynchronous to the test clock. The chain stores whatever level is present at that edge and does not filter it.

Top module: `bscan_chain`

## Requirements
- R1: While the asynchronous power-up reset `porN` is low, every shift flop is 0. Every holding latch is 0, except the output-enable cell at index `OE_CELL` (47 by default), which is 1. So `outBusEn` is 1.
- R2: On a rising `tck` edge with `sel` and `captureDr` high and `tlr` low, shift flop i loads `pinIn[i]` for every i. `tdoOut` then shows `pinIn[0]`.
- R3: On a rising `tck` edge with `sel` and `shiftDr` high and `captureDr` and `tlr` low, cell i takes the old value of cell i+1 and the last cell takes `tdi`. `tdoOut` always shows cell 0. After `CHAIN_LEN` shifts, the bits captured earlier have left the chain, cell 0 first, and the bits shifted in sit in the chain with the k-th bit shifted in at cell k.
- R4: On a rising `tck` edge with `sel` and `updateDr` high and `tlr` low, `preloadOut` takes the shift-flop contents as they stood before that edge.
- R5: `outBusEn` equals the holding latch of cell `OE_CELL`. This cell is set by shifting a bit into that position and then updating, and it can be cleared to 0 the same way.
- R6: On a rising `tck` edge with `tlr` high, `preloadOut` becomes the reset pattern (only cell `OE_CELL` set), whatever the other strobes are doing. The shift flops keep their values.
- R7: While `sel` is low, the capture, shift and update strobes have no effect: both the shift flops and `preloadOut` keep their values.
- R8: `preloadOut` changes only on an update or a Test-Logic-Reset edge. It stays steady through capture and shift operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| porN | input | 1 | Asynchronous power-up reset, active low |
| tdi | input | 1 | Serial data entering the last cell |
| sel | input | 1 | Chain selected by the current instruction |
| captureDr | input | 1 | TAP is in Capture-DR |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| pinIn | input | CHAIN_LEN | Sampled pin values, one per cell |
| tdoOut | output | 1 | Serial output taken from cell 0 |
| preloadOut | output | CHAIN_LEN | Holding-latch vector used to drive pins |
| outBusEn | output | 1 | Output-bus enable from the output-enable cell latch |

## Verification
On every clock, the bound checker checks the cell-to-cell effect of each strobe. It checks the capture snapshot, the one-place shift with `tdi` entering at the top, and the copy into the latches on update. It also checks the preset on Test-Logic-Reset, that everything holds while the chain is deselected, and that the latches stay steady outside update. Some behaviour only the bench scenarios can show. One is the full serial round trip, where a captured word leaves the chain in order while a new word enters. Another is setting and clearing the output-enable cell through shifting. A third is the power-up pattern. The last is that the shift-flop contents survive a Test-Logic-Reset and can be read out afterwards. A behavioural model checks all outputs on every cycle under random strobes as well.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Per-edge strobes handed from the control decode to the cell datapath.
  typedef struct packed {
    logic capEn;     // load pin snapshot into shift flops
    logic shiftEn;   // move chain one place toward cell 0
    logic updEn;     // copy shift flops into holding latches
    logic presetEn;  // force holding latches to reset pattern
  } bscanStrobe_t;

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic         sel,
  input  logic         captureDr,
  input  logic         shiftDr,
  input  logic         updateDr,
  input  logic         tlr,
  output bscanStrobe_t strobe
);

  // Test-Logic-Reset overrides every other request; capture outranks shift.
  always_comb begin
    strobe          = '0;
    strobe.presetEn = tlr;
    if (!tlr && sel) begin
      strobe.capEn   = captureDr;
      strobe.shiftEn = shiftDr && !captureDr;
      strobe.updEn   = updateDr;
    end
  end

endmodule

// File: rtl/bscan_datapath.sv
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int CHAIN_LEN = 48,
  parameter int OE_CELL   = 47
) (
  input  logic                 tck,
  input  logic                 porN,
  input  logic                 tdi,
  input  bscanStrobe_t         strobe,
  input  logic [CHAIN_LEN-1:0] pinIn,
  output logic [CHAIN_LEN-1:0] shiftStage,
  output logic [CHAIN_LEN-1:0] holdLatch
);

  localparam logic [CHAIN_LEN-1:0] RESET_PAT = CHAIN_LEN'(1) << OE_CELL;
  localparam int TOP_CELL = CHAIN_LEN - 1;

  // Serial input to each cell: the neighbour above, or tdi at the top.
  logic [CHAIN_LEN-1:0] serialIn;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == TOP_CELL) begin : g_top
      assign serialIn[i] = tdi;
    end else begin : g_mid
      assign serialIn[i] = shiftStage[i+1];
    end

    always_ff @(posedge tck or negedge porN) begin
      if (!porN) begin
        shiftStage[i] <= 1'b0;
      end else if (strobe.capEn) begin
        shiftStage[i] <= pinIn[i];
      end else if (strobe.shiftEn) begin
        shiftStage[i] <= serialIn[i];
      end
    end

    always_ff @(posedge tck or negedge porN) begin
      if (!porN) begin
        holdLatch[i] <= RESET_PAT[i];
      end else if (strobe.presetEn) begin
        holdLatch[i] <= RESET_PAT[i];
      end else if (strobe.updEn) begin
        holdLatch[i] <= shiftStage[i];
      end
    end
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int CHAIN_LEN = 48,
  parameter int OE_CELL   = 47
) (
  input  logic                 tck,
  input  logic                 porN,
  input  logic                 tdi,
  input  logic                 sel,
  input  logic                 captureDr,
  input  logic                 shiftDr,
  input  logic                 updateDr,
  input  logic                 tlr,
  input  logic [CHAIN_LEN-1:0] pinIn,
  output logic                 tdoOut,
  output logic [CHAIN_LEN-1:0] preloadOut,
  output logic                 outBusEn
);

  bscanStrobe_t         strobe;
  logic [CHAIN_LEN-1:0] shiftStage;

  bscan_ctrl ctrl_i (
    .sel       (sel),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .tlr       (tlr),
    .strobe    (strobe)
  );

  bscan_datapath #(
    .CHAIN_LEN (CHAIN_LEN),
    .OE_CELL   (OE_CELL)
  ) dp_i (
    .tck        (tck),
    .porN       (porN),
    .tdi        (tdi),
    .strobe     (strobe),
    .pinIn      (pinIn),
    .shiftStage (shiftStage),
    .holdLatch  (preloadOut)
  );

  assign tdoOut   = shiftStage[0];
  assign outBusEn = preloadOut[OE_CELL];

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int CHAIN_LEN = 48,
  parameter int OE_CELL   = 47
) (
  input logic                 tck,
  input logic                 porN,
  input logic                 tdi,
  input logic                 sel,
  input logic                 captureDr,
  input logic                 shiftDr,
  input logic                 updateDr,
  input logic                 tlr,
  input logic [CHAIN_LEN-1:0] pinIn,
  input logic [CHAIN_LEN-1:0] shiftStage,
  input logic [CHAIN_LEN-1:0] preloadOut,
  input logic                 outBusEn
);

  localparam logic [CHAIN_LEN-1:0] RESET_PAT = CHAIN_LEN'(1) << OE_CELL;

  // R2
  capture_snapshot_chk: assert property (@(posedge tck) disable iff (!porN)
    (sel && captureDr && !tlr) |=> (shiftStage == $past(pinIn)));

  // R3
  shift_one_place_chk: assert property (@(posedge tck) disable iff (!porN)
    (sel && shiftDr && !captureDr && !tlr) |=>
      (shiftStage == {$past(tdi), $past(shiftStage[CHAIN_LEN-1:1])}));

  // R4
  update_copy_chk: assert property (@(posedge tck) disable iff (!porN)
    (sel && updateDr && !tlr) |=> (preloadOut == $past(shiftStage)));

  // R6
  tlr_preset_chk: assert property (@(posedge tck) disable iff (!porN)
    tlr |=> (preloadOut == RESET_PAT) && $stable(shiftStage));

  // R5
  tlr_enable_chk: assert property (@(posedge tck) disable iff (!porN)
    tlr |=> outBusEn);

  // R7
  deselect_hold_chk: assert property (@(posedge tck) disable iff (!porN)
    (!sel && !tlr) |=> ($stable(preloadOut) && $stable(shiftStage)));

  // R8
  latch_steady_chk: assert property (@(posedge tck) disable iff (!porN)
    (!updateDr && !tlr) |=> $stable(preloadOut));

endmodule

bind bscan_chain bscan_chain_chk #(
  .CHAIN_LEN (CHAIN_LEN),
  .OE_CELL   (OE_CELL)
) chk_i (
  .tck        (tck),
  .porN       (porN),
  .tdi        (tdi),
  .sel        (sel),
  .captureDr  (captureDr),
  .shiftDr    (shiftDr),
  .updateDr   (updateDr),
  .tlr        (tlr),
  .pinIn      (pinIn),
  .shiftStage (shiftStage),
  .preloadOut (preloadOut),
  .outBusEn   (outBusEn)
);

// File: tb/bscan_chain_tb_top.sv
module bscan_chain_tb_top;

  localparam int LEN       = 48;
  localparam int OE        = 47;
  localparam int CLK_NS    = 50;
  localparam logic [LEN-1:0] RST_PAT = LEN'(1) << OE;

  logic           clk = 1'b0;
  logic           porN = 1'b0;
  logic           tdi = 1'b0;
  logic           sel = 1'b0;
  logic           captureDr = 1'b0;
  logic           shiftDr = 1'b0;
  logic           updateDr = 1'b0;
  logic           tlr = 1'b0;
  logic [LEN-1:0] pinIn = '0;
  logic           tdoOut;
  logic [LEN-1:0] preloadOut;
  logic           outBusEn;

  int errCnt = 0;
  int chkCnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  bscan_chain #(.CHAIN_LEN(LEN), .OE_CELL(OE)) dut_i (
    .tck(clk), .porN(porN), .tdi(tdi), .sel(sel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tlr(tlr), .pinIn(pinIn),
    .tdoOut(tdoOut), .preloadOut(preloadOut), .outBusEn(outBusEn)
  );

  // Behavioural reference: shift flops as a queue, front element = cell 0.
  bit             mSr[$];
  logic [LEN-1:0] mLat;

  function automatic logic [LEN-1:0] srVec();
    logic [LEN-1:0] v = '0;
    for (int i = 0; i < LEN; i++) v[i] = mSr[i];
    return v;
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mSr = {};
      for (int i = 0; i < LEN; i++) mSr.push_back(1'b0);
      mLat = RST_PAT;
    end else if (tlr) begin
      mLat = RST_PAT;
    end else if (sel) begin
      if (updateDr) mLat = srVec();
      if (captureDr) begin
        for (int i = 0; i < LEN; i++) mSr[i] = pinIn[i];
      end else if (shiftDr) begin
        void'(mSr.pop_front());
        mSr.push_back(tdi);
      end
    end
  end

  task automatic check(string req, logic [LEN-1:0] act, logic [LEN-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareModel();
    check("R3 tdoOut", LEN'(tdoOut), LEN'(mSr[0]));
    check("R4 preloadOut", preloadOut, mLat);
    check("R5 outBusEn", LEN'(outBusEn), LEN'(mLat[OE]));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  task automatic idle();
    captureDr = 1'b0; shiftDr = 1'b0; updateDr = 1'b0; tlr = 1'b0;
  endtask

  // Shift LEN bits: inBits[k] enters k-th, outBits[k] is what left k-th.
  task automatic shiftWord(input logic [LEN-1:0] inBits, output logic [LEN-1:0] outBits);
    outBits = '0;
    for (int k = 0; k < LEN; k++) begin
      outBits[k] = tdoOut;
      tdi = inBits[k];
      shiftDr = 1'b1;
      step();
    end
    shiftDr = 1'b0;
  endtask

  task automatic pulseCapture(input logic [LEN-1:0] pins);
    pinIn = pins; captureDr = 1'b1; step(); captureDr = 1'b0;
  endtask

  task automatic pulseUpdate();
    updateDr = 1'b1; step(); updateDr = 1'b0;
  endtask

  logic [LEN-1:0] patA, patB, patC, got;

  initial begin
    repeat (2) @(negedge clk);
    // R1: power-up state
    check("R1 preloadOut", preloadOut, RST_PAT);
    check("R1 outBusEn", LEN'(outBusEn), LEN'(1));
    check("R1 tdoOut", LEN'(tdoOut), '0);
    porN = 1'b1;
    step();

    // R2/R3/R4/R5: capture A, shift out A while B enters, update B
    patA = 48'hA5C3_0F1E_9B27;
    patB = 48'h3C69_D2E1_5A0F;   // bit 47 = 0: drives outputs to high-Z
    sel = 1'b1;
    pulseCapture(patA);
    check("R2 tdoOut after capture", LEN'(tdoOut), LEN'(patA[0]));
    shiftWord(patB, got);
    check("R3 captured word shifted out", got, patA);
    pulseUpdate();
    check("R4 latch after update", preloadOut, patB);
    check("R5 outBusEn cleared", LEN'(outBusEn), '0);

    // R8: latch steady through capture and shift
    pulseCapture(~patB);
    shiftWord(patA, got);
    check("R8 latch held over capture/shift", preloadOut, patB);
    check("R3 second word out", got, ~patB);

    // R5: set the enable cell back to 1 via shift + update
    patC = patA | RST_PAT;
    shiftWord(patC, got);
    pulseUpdate();
    check("R5 outBusEn set", LEN'(outBusEn), LEN'(1));
    check("R4 latch second update", preloadOut, patC);

    // R7: deselected strobes do nothing
    sel = 1'b0;
    pulseCapture(48'hFFFF_0000_FFFF);
    tdi = 1'b1; shiftDr = 1'b1; step(); step(); shiftDr = 1'b0;
    pulseUpdate();
    check("R7 latch unchanged when deselected", preloadOut, patC);
    check("R7 tdoOut unchanged when deselected", LEN'(tdoOut), LEN'(patC[0]));
    sel = 1'b1;
    shiftWord(patB, got);
    check("R7 shift flops unchanged when deselected", got, patC);

    // R6: Test-Logic-Reset presets latch, wins over update, keeps shift flops
    tlr = 1'b1; updateDr = 1'b1; step(); updateDr = 1'b0; step(); tlr = 1'b0;
    check("R6 latch preset", preloadOut, RST_PAT);
    check("R6 outBusEn preset", LEN'(outBusEn), LEN'(1));
    shiftWord(patA, got);
    check("R6 shift flops kept through reset", got, patB);

    // Random strobes, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      int pick;
      idle();
      pick       = $urandom_range(0, 15);
      sel        = ($urandom_range(0, 7) != 0);
      tlr        = (pick == 0);
      captureDr  = (pick inside {[1:2]});
      shiftDr    = (pick inside {[3:11]});
      updateDr   = (pick inside {[12:13]});
      tdi        = 1'($urandom);
      pinIn      = {16'($urandom), 32'($urandom)};
      step();
    end
    idle();

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL R1-watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule